// File: doc/BRIEF.md
# GPIO Interrupt Detection and Status Unit

This unit watches 32 general-purpose input pins and turns selected pin activity into interrupt requests. The pins form two halves: pins 0 to 15 (low copy) and pins 16 to 31 (high copy). Each half has its own set of 16-bit control and status registers on a small write/read register bus. Every pin is first brought into the clock domain through a synchronizer. It can then be set up for level sensing with a chosen polarity, or for edge sensing on the falling edge, the rising edge or both. For edge sensing, the event is either held in the status bit until software clears it, or passed through as a single-cycle indication.

Status bits are qualified by per-pin enables. The qualified bits drive one combined interrupt line toward the wider interrupt controller. A priority helper reports the index of the pin that software should service first. A spurious flag marks cycles in which the combined line is high but no enabled status bit remains set. This happens, for example, right after software has cleared the last pending bit.

Top module: `gpirq_unit`

## Requirements
- R1: While reset is asserted, every enable, type, polarity, hold, falling-select, rising-select and status bit reads 0, and `irq_out` and `pend_valid` are 0.
- R2: Registers sit at these byte addresses, low copy first and high copy 2 bytes above it: status 0x08/0x0A, enable 0x0C/0x0E, type 0x10/0x12, polarity 0x14/0x16, hold 0x18/0x1A, falling select 0x20/0x22, rising select 0x24/0x26. Bit i of a low copy is pin i, and bit i of a high copy is pin 16+i. Enable, type, polarity, falling-select and rising-select bits read back as written. Any other address reads 0.
- R3: For a pin whose type bit is 0 (level), the status bit is 1 exactly while the synchronized pin equals its polarity bit (1 = active high, 0 = active low). The status bit responds on the third rising clock edge after the pin changes. A clear write does not remove a level status while the level is active.
- R4: For a pin whose type bit is 1 (edge), a 0-to-1 change counts as an event only if its rising-select bit is 1. A 1-to-0 change counts only if its falling-select bit is 1. With both bits set, either change counts. The event reaches the status bit on the third rising edge after the pin changes.
- R5: For an edge pin with hold bit 1, an event sets the status bit and it stays set until a status write with a 1 in that bit position. A 0 in the write data leaves that bit unchanged.
- R6: For an edge pin with hold bit 0, each event makes the status bit 1 for exactly one clock cycle.
- R7: When an event and a clear write for the same held status bit meet on one clock edge, the bit ends up set.
- R8: A hold bit can only be 1 for a pin whose type bit is 1. Hold bits written for level pins read back 0, and changing a type bit to 0 clears that pin's hold bit.
- R9: A pin is pending when its status and enable bits are both 1. `pend_valid` shows whether any pin is pending. `pend_idx` gives the lowest pending pin of the low half, or, if none is pending there, the lowest pending pin of the high half. The value is updated in the same cycle as the status.
- R10: `irq_out` is the OR of all pending bits, registered, so it follows the pending set one clock cycle later.
- R11: `irq_spurious` is 1 exactly when `irq_out` is 1 and no pin is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 32 | Raw pin levels, asynchronous to `clk` |
| bus_we | input | 1 | Register write strobe, sampled on the rising edge |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| irq_out | output | 1 | Combined interrupt request |
| irq_spurious | output | 1 | Request high while nothing is pending |
| pend_valid | output | 1 | At least one pin is pending |
| pend_idx | output | 5 | Index of the pin to service first |

## Verification
The risky overlap is a pin event and a software clear for the same held status bit arriving on the same clock edge. The bench raises a rising-edge, held pin and issues the clear write two clock cycles later, so that both are sampled on the third edge. It then expects the bit to read back 1, and expects a second clear to remove it. A related overlap, a clear landing while the registered request is still high, is judged by reading `irq_spurious` in the cycle right after the clear.

// File: rtl/gpirq_pkg.sv
package gpirq_pkg;

   // Register group selected by byte address bits [5:2]; bit [1] picks the half.
   typedef enum logic [3:0] {
      GRP_STAT = 4'd2,
      GRP_EN   = 4'd3,
      GRP_TYPE = 4'd4,
      GRP_POL  = 4'd5,
      GRP_HOLD = 4'd6,
      GRP_FALL = 4'd8,
      GRP_RISE = 4'd9
   } gpirq_grp_e;

   localparam int unsigned GPIRQ_ADDR_W = 6;

endpackage

// File: rtl/gpirq_sync.sv
module gpirq_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int unsigned CW = W * STAGES;

   if (STAGES < 2) begin : g_bad_stages
      $error("gpirq_sync: STAGES must be at least 2");
   end

   logic [CW-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[CW-W-1:0], d};
   end

   assign q = chain[CW-1 -: W];

endmodule

// File: rtl/gpirq_regs.sv
module gpirq_regs
   import gpirq_pkg::*;
#(
   parameter int unsigned DW          = 16,
   parameter bit          EDGE_SEL_EN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_we,
   input  logic [GPIRQ_ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]           bus_wdata,
   output logic [DW-1:0]           bus_rdata,
   input  logic [2*DW-1:0]         status,
   output logic [2*DW-1:0]         en,
   output logic [2*DW-1:0]         typ,
   output logic [2*DW-1:0]         pol,
   output logic [2*DW-1:0]         hold,
   output logic [2*DW-1:0]         fall_sel,
   output logic [2*DW-1:0]         rise_sel,
   output logic [2*DW-1:0]         clr
);
   localparam int unsigned NP = 2 * DW;

   logic [3:0] grp;
   logic       hi;
   logic       unused_a0;

   assign grp       = bus_addr[5:2];
   assign hi        = bus_addr[1];
   assign unused_a0 = bus_addr[0];

   logic [1:0][DW-1:0] en_q, typ_q, pol_q, hold_q, fall_q, rise_q, st_v, rsel, clr_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         typ_q  <= '0;
         pol_q  <= '0;
         hold_q <= '0;
      end else if (bus_we) begin
         case (grp)
            GRP_EN:   en_q[hi] <= bus_wdata;
            GRP_TYPE: begin
               typ_q[hi]  <= bus_wdata;
               hold_q[hi] <= hold_q[hi] & bus_wdata;
            end
            GRP_POL:  pol_q[hi]  <= bus_wdata;
            GRP_HOLD: hold_q[hi] <= bus_wdata & typ_q[hi];
            default:  ;
         endcase
      end
   end

   // Edge-select registers exist only in the selectable-edge variant.
   if (EDGE_SEL_EN) begin : g_edge_sel
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            fall_q <= '0;
            rise_q <= '0;
         end else if (bus_we) begin
            if (grp == GRP_FALL) fall_q[hi] <= bus_wdata;
            if (grp == GRP_RISE) rise_q[hi] <= bus_wdata;
         end
      end
   end else begin : g_no_edge_sel
      assign fall_q = '0;
      assign rise_q = '0;
   end

   // Write-one-to-clear strobe toward the status bits.
   always_comb begin
      clr_v = '0;
      if (bus_we && grp == GRP_STAT) clr_v[hi] = bus_wdata;
   end

   assign st_v = status;

   always_comb begin
      case (grp)
         GRP_STAT: rsel = st_v;
         GRP_EN:   rsel = en_q;
         GRP_TYPE: rsel = typ_q;
         GRP_POL:  rsel = pol_q;
         GRP_HOLD: rsel = hold_q;
         GRP_FALL: rsel = fall_q;
         GRP_RISE: rsel = rise_q;
         default:  rsel = '0;
      endcase
   end

   assign bus_rdata = rsel[hi];
   assign en        = en_q;
   assign typ       = typ_q;
   assign pol       = pol_q;
   assign hold      = hold_q;
   assign fall_sel  = fall_q;
   assign rise_sel  = rise_q;
   assign clr       = clr_v;

   // R8: hold may only be set on edge pins
   p_hold_edge_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hold & ~typ) == '0);

   // R2: enable write lands in the addressed half
   p_en_write_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && grp == GRP_EN && !hi) |=> (en[DW-1:0] == $past(bus_wdata)));

   p_en_write_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && grp == GRP_EN && hi) |=> (en[NP-1:DW] == $past(bus_wdata)));

endmodule

// File: rtl/gpirq_detect.sv
module gpirq_detect #(
   parameter int unsigned NP          = 32,
   parameter bit          EDGE_SEL_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NP-1:0] pin_s,
   input  logic [NP-1:0] typ,
   input  logic [NP-1:0] pol,
   input  logic [NP-1:0] hold,
   input  logic [NP-1:0] fall_sel,
   input  logic [NP-1:0] rise_sel,
   input  logic [NP-1:0] clr,
   output logic [NP-1:0] status
);
   logic [NP-1:0] prev_s, up_ev, dn_ev, edge_ev, st_nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_s <= '0;
      else        prev_s <= pin_s;
   end

   assign up_ev = pin_s & ~prev_s;
   assign dn_ev = ~pin_s & prev_s;

   if (EDGE_SEL_EN) begin : g_sel_edges
      assign edge_ev = (up_ev & rise_sel) | (dn_ev & fall_sel);
   end else begin : g_any_edge
      logic [NP-1:0] unused_sel;
      assign unused_sel = fall_sel ^ rise_sel;
      assign edge_ev    = up_ev | dn_ev;
   end

   for (genvar i = 0; i < NP; i++) begin : g_pin
      always_comb begin
         if (!typ[i])      st_nxt[i] = (pin_s[i] == pol[i]);
         else if (hold[i]) st_nxt[i] = edge_ev[i] | (status[i] & ~clr[i]);
         else              st_nxt[i] = edge_ev[i];
      end

      // R5: held status survives a cycle without clear
      p_hold_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (typ[i] && hold[i] && status[i] && !clr[i]) |=> status[i]);

      // R5: clear without event removes held status
      p_hold_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (typ[i] && hold[i] && clr[i] && !edge_ev[i]) |=> !status[i]);

      // R7: event beats a simultaneous clear
      p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (typ[i] && hold[i] && edge_ev[i] && clr[i]) |=> status[i]);

      // R6: pass-through status drops when no new event
      p_thru_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (typ[i] && !hold[i] && !edge_ev[i]) |=> !status[i]);

      // R3: level status tracks the synchronized pin against polarity
      p_level_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (!typ[i]) |=> (status[i] == $past(pin_s[i] == pol[i])));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status <= '0;
      else        status <= st_nxt;
   end

endmodule

// File: rtl/gpirq_prio.sv
module gpirq_prio #(
   parameter int unsigned DW = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [2*DW-1:0]           pending,
   output logic                      valid,
   output logic [$clog2(2*DW)-1:0]   idx
);
   localparam int unsigned NP = 2 * DW;
   localparam int unsigned IW = $clog2(NP);
   localparam int unsigned HW = $clog2(DW);

   logic [1:0] any_h;

   for (genvar h = 0; h < 2; h++) begin : g_half
      logic [HW-1:0] loc;
      always_comb begin
         loc = '0;
         for (int j = DW - 1; j >= 0; j--) begin
            if (pending[h*DW + j]) loc = HW'(j);
         end
      end
      assign any_h[h] = |pending[h*DW +: DW];
   end

   always_comb begin
      valid = |any_h;
      if (any_h[0]) idx = IW'(g_half[0].loc);
      else if (any_h[1]) idx = IW'(DW) + IW'(g_half[1].loc);
      else idx = '0;
   end

   logic [NP-1:0] below_m;
   assign below_m = (NP'(1) << idx) - NP'(1);

   // R9: reported pin is pending
   p_idx_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> pending[idx]);

   // R9: no pending pin below the reported one
   p_idx_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> ((pending & below_m) == '0));

   // R9: not valid means nothing pending
   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> (pending == '0));

endmodule

// File: rtl/gpirq_unit.sv
module gpirq_unit
   import gpirq_pkg::*;
#(
   parameter int unsigned DW          = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          EDGE_SEL_EN = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [2*DW-1:0]            pin_in,
   input  logic                       bus_we,
   input  logic [GPIRQ_ADDR_W-1:0]    bus_addr,
   input  logic [DW-1:0]              bus_wdata,
   output logic [DW-1:0]              bus_rdata,
   output logic                       irq_out,
   output logic                       irq_spurious,
   output logic                       pend_valid,
   output logic [$clog2(2*DW)-1:0]    pend_idx
);
   localparam int unsigned NP = 2 * DW;

   if (DW < 2 || DW > 16) begin : g_bad_dw
      $error("gpirq_unit: DW must lie in 2..16");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpirq_unit: SYNC_STAGES must be at least 2");
   end

   logic [NP-1:0] pin_s, en, typ, pol, hold, fall_sel, rise_sel, clr, status, pending;
   logic          irq_q;

   gpirq_sync #(.W(NP), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_s)
   );

   gpirq_regs #(.DW(DW), .EDGE_SEL_EN(EDGE_SEL_EN)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .status    (status),
      .en        (en),
      .typ       (typ),
      .pol       (pol),
      .hold      (hold),
      .fall_sel  (fall_sel),
      .rise_sel  (rise_sel),
      .clr       (clr)
   );

   gpirq_detect #(.NP(NP), .EDGE_SEL_EN(EDGE_SEL_EN)) u_detect (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_s    (pin_s),
      .typ      (typ),
      .pol      (pol),
      .hold     (hold),
      .fall_sel (fall_sel),
      .rise_sel (rise_sel),
      .clr      (clr),
      .status   (status)
   );

   assign pending = status & en;

   gpirq_prio #(.DW(DW)) u_prio (
      .clk     (clk),
      .rst_n   (rst_n),
      .pending (pending),
      .valid   (pend_valid),
      .idx     (pend_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |pending;
   end

   assign irq_out      = irq_q;
   assign irq_spurious = irq_q & ~pend_valid;

   // R10: any pending pin raises the request on the next cycle
   p_irq_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pend_valid |=> irq_out);

   p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_valid |=> !irq_out);

   // R11: spurious only right after the pending set emptied
   p_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_spurious |-> ($past(pend_valid) && !pend_valid));

endmodule

// File: tb/gpirq_unit_tb.sv
module gpirq_unit_tb_top;

   localparam logic [5:0] A_ST_L = 6'h08, A_ST_H = 6'h0A;
   localparam logic [5:0] A_EN_L = 6'h0C, A_EN_H = 6'h0E;
   localparam logic [5:0] A_TY_L = 6'h10, A_TY_H = 6'h12;
   localparam logic [5:0] A_PO_L = 6'h14, A_PO_H = 6'h16;
   localparam logic [5:0] A_HO_L = 6'h18, A_HO_H = 6'h1A;
   localparam logic [5:0] A_FA_L = 6'h20, A_FA_H = 6'h22;
   localparam logic [5:0] A_RI_L = 6'h24, A_RI_H = 6'h26;

   // {pins, expected status, expected valid, expected index}
   localparam int NVEC = 7;
   localparam logic [69:0] TBL [NVEC] = '{
      {32'hFFEDFFCA, 32'h0000_0000, 1'b0, 5'd0},
      {32'hFFEDFFCB, 32'h0000_0001, 1'b1, 5'd0},
      {32'hFFEDFFCE, 32'h0000_0004, 1'b1, 5'd2},
      {32'hFFEDFFC6, 32'h0000_000C, 1'b1, 5'd2},
      {32'hFFEDFFD2, 32'h0000_001C, 1'b1, 5'd2},
      {32'hFFEDFFE2, 32'h0000_003C, 1'b1, 5'd2},
      {32'hFFEFFFE0, 32'h0002_001E, 1'b1, 5'd1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pin_in = 32'hFFEDFFCA;
   logic        bus_we = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq_out, irq_spurious, pend_valid;
   logic [4:0]  pend_idx;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   gpirq_unit dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .pin_in       (pin_in),
      .bus_we       (bus_we),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .irq_out      (irq_out),
      .irq_spurious (irq_spurious),
      .pend_valid   (pend_valid),
      .pend_idx     (pend_idx)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic reg_wr(input logic [5:0] a, input logic [15:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic reg_rd(input logic [5:0] a, output logic [15:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic pins_wait(input logic [31:0] v, input int n);
      pin_in = v;
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] lo, hi;
      repeat (2) @(negedge clk);
      // R1 reset state
      reg_rd(A_EN_L, lo); chk("R1 enable low", {16'h0, lo}, 32'h0);
      reg_rd(A_TY_H, lo); chk("R1 type high", {16'h0, lo}, 32'h0);
      reg_rd(A_HO_L, lo); chk("R1 hold low", {16'h0, lo}, 32'h0);
      reg_rd(A_RI_L, lo); chk("R1 rise low", {16'h0, lo}, 32'h0);
      reg_rd(A_ST_L, lo); chk("R1 status low", {16'h0, lo}, 32'h0);
      chk("R1 irq_out", {31'h0, irq_out}, 32'h0);
      chk("R1 pend_valid", {31'h0, pend_valid}, 32'h0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      reg_wr(A_EN_L, 16'h003F); reg_wr(A_EN_H, 16'h0012);
      reg_wr(A_TY_L, 16'h003C); reg_wr(A_TY_H, 16'h0002);
      reg_wr(A_PO_L, 16'h0001); reg_wr(A_PO_H, 16'h0010);
      reg_wr(A_HO_L, 16'h001C); reg_wr(A_HO_H, 16'h0002);
      reg_wr(A_FA_L, 16'h0018);
      reg_wr(A_RI_L, 16'h0034); reg_wr(A_RI_H, 16'h0002);
      repeat (4) @(negedge clk);
      reg_wr(A_ST_L, 16'hFFFF); reg_wr(A_ST_H, 16'hFFFF);
      repeat (2) @(negedge clk);

      // table walk: R3 level, R4 edge selects, R5 hold, R6 pass-through, R9 priority
      for (int v = 0; v < NVEC; v++) begin
         pins_wait(TBL[v][69:38], 3);
         reg_rd(A_ST_L, lo); reg_rd(A_ST_H, hi);
         chk($sformatf("R3 R4 R5 R6 status vec %0d", v), {hi, lo}, TBL[v][37:6]);
         chk($sformatf("R9 valid vec %0d", v), {31'h0, pend_valid}, {31'h0, TBL[v][5]});
         if (TBL[v][5]) chk($sformatf("R9 index vec %0d", v), {27'h0, pend_idx}, {27'h0, TBL[v][4:0]});
      end

      // R5: zero write leaves held bit
      reg_wr(A_ST_H, 16'h0000);
      reg_rd(A_ST_H, hi); chk("R5 zero write keeps", {16'h0, hi}, 32'h0002);
      // R3: clear does not remove active level; held bits go
      reg_wr(A_ST_L, 16'h001E);
      reg_rd(A_ST_L, lo); chk("R3 R5 clear low", {16'h0, lo}, 32'h0002);
      // R9: only high half pending
      pins_wait(32'hFFEFFFE2, 3);
      reg_rd(A_ST_L, lo); chk("R3 level released", {16'h0, lo}, 32'h0);
      chk("R9 high half index", {27'h0, pend_idx}, 32'd17);
      // R11: spurious after clearing the last pending bit
      chk("R10 irq before clear", {31'h0, irq_out}, 32'h1);
      reg_wr(A_ST_H, 16'h0002);
      reg_rd(A_ST_H, hi); chk("R5 high clear", {16'h0, hi}, 32'h0);
      chk("R11 irq still high", {31'h0, irq_out}, 32'h1);
      chk("R11 spurious", {31'h0, irq_spurious}, 32'h1);
      @(negedge clk);
      chk("R10 irq dropped", {31'h0, irq_out}, 32'h0);
      chk("R11 spurious gone", {31'h0, irq_spurious}, 32'h0);
      // R10: one-cycle latency
      pins_wait(32'hFFEFFFE3, 3);
      chk("R10 pending seen", {31'h0, pend_valid}, 32'h1);
      chk("R10 irq not yet", {31'h0, irq_out}, 32'h0);
      @(negedge clk);
      chk("R10 irq raised", {31'h0, irq_out}, 32'h1);
      // R9: low half wins over high half
      pins_wait(32'hFFEDFFE3, 3);
      pins_wait(32'hFFEFFFE3, 3);
      reg_rd(A_ST_H, hi); chk("R4 high rising", {16'h0, hi}, 32'h0002);
      chk("R9 low before high", {27'h0, pend_idx}, 32'd0);
      pins_wait(32'hFFEFFFE2, 3);
      chk("R9 falls back to high", {27'h0, pend_idx}, 32'd17);
      // R6: pass-through pulse lasts one cycle
      pins_wait(32'hFFEFFFC2, 3);
      pins_wait(32'hFFEFFFE2, 3);
      reg_rd(A_ST_L, lo); chk("R6 pulse on", {16'h0, lo}, 32'h0020);
      @(negedge clk);
      reg_rd(A_ST_L, lo); chk("R6 pulse off", {16'h0, lo}, 32'h0);
      // R7: event and clear on the same edge
      pins_wait(32'hFFEFFFE6, 2);
      reg_wr(A_ST_L, 16'h0004);
      reg_rd(A_ST_L, lo); chk("R7 set wins", {16'h0, lo}, 32'h0004);
      reg_wr(A_ST_L, 16'h0004);
      reg_rd(A_ST_L, lo); chk("R5 later clear", {16'h0, lo}, 32'h0);
      // R8: hold restricted to edge pins
      reg_wr(A_HO_L, 16'hFFFF);
      reg_rd(A_HO_L, lo); chk("R8 hold masked", {16'h0, lo}, 32'h003C);
      reg_wr(A_TY_L, 16'h0018);
      reg_rd(A_HO_L, lo); chk("R8 hold follows type", {16'h0, lo}, 32'h0018);
      // R2: readback and unmapped
      reg_rd(A_TY_L, lo); chk("R2 type low", {16'h0, lo}, 32'h0018);
      reg_rd(A_EN_H, lo); chk("R2 enable high", {16'h0, lo}, 32'h0012);
      reg_rd(A_PO_H, lo); chk("R2 polarity high", {16'h0, lo}, 32'h0010);
      reg_rd(A_FA_L, lo); chk("R2 fall low", {16'h0, lo}, 32'h0018);
      reg_rd(A_FA_H, lo); chk("R2 fall high", {16'h0, lo}, 32'h0);
      reg_rd(A_RI_L, lo); chk("R2 rise low", {16'h0, lo}, 32'h0034);
      reg_rd(A_RI_H, lo); chk("R2 rise high", {16'h0, lo}, 32'h0002);
      reg_rd(6'h00, lo);  chk("R2 unmapped 0x00", {16'h0, lo}, 32'h0);
      reg_rd(6'h1C, lo);  chk("R2 unmapped 0x1C", {16'h0, lo}, 32'h0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule